// File: doc/BRIEF.md
# Timer Control and Snapshot Latch

This block holds a 16-bit up-counting timer and a 24-bit overflow counter, both with a period register and two compare registers. It is controlled through a byte-wide register bus. A start or stop request is written into the control register. It takes effect either on the next fast clock edge or at the next rising edge of a slow 32 kHz reference. The slow reference is brought into the fast domain through a two-flop synchronizer.

Multi-byte counter values are read one byte at a time. Reading a low byte captures the upper bytes in the same cycle, so the later byte reads form a consistent value. A mode bit chooses between two ways of doing this. In the first, each counter is snapshotted on its own low-byte read. In the second, one timer low-byte read snapshots the timer and the overflow counter together. Two event outputs each pick one of six timer or overflow events through a 3-bit selector and pulse for one cycle when it occurs.

Top module: `tmr_latch_ctrl`

## Requirements
- R1: After reset, CTRL reads 0x02, EVT reads 0x00, MUX reads 0x00, the timer count is 0, and the timer and overflow period registers hold all ones.
- R2: CTRL (address 0) has bit 0 run request, bit 1 sync, bit 2 running state (read-only, writes ignored) and bit 3 latch mode. Bits 7:4 read 0. The run bit reads back the last value written, whatever the running state is.
- R3: With sync=0, the running state takes the written run value one cycle after the write.
- R4: With sync=1, the running state changes only after a rising edge of the slow clock input, which reaches the fast domain within three fast cycles. It is held through slow falling edges and while the slow input is steady.
- R5: While running, the timer increments by one per cycle. In a cycle where it is at or above its period it wraps to 0. While idle, both counters hold their values.
- R6: Each timer wrap increments the overflow counter. When a wrap occurs and the overflow counter is at or above its own period, the overflow counter returns to 0 instead.
- R7: Reading TLO (address 2) with timer select 0 returns the live low byte and captures the live high byte. A read of THI (address 3) with timer select 0 returns that captured byte. The captured byte changes only on such a TLO read.
- R8: With latch mode 0, reading OV0 (address 4) with overflow select 0 returns the live byte 0 and captures bytes 1 and 2. OV1 and OV2 (addresses 5, 6) then return the captured bytes.
- R9: With latch mode 1, a TLO read with timer select 0 captures the timer high byte and all three overflow bytes in that same cycle. OV0, OV1 and OV2 then return the captured bytes.
- R10: EVT (address 7) has a selector for output 0 in bits 2:0 and one for output 1 in bits 6:4. The codes are: 0 timer wrap, 1 timer count equals compare 1, 2 timer count equals compare 2, 3 overflow wrap, 4 timer wrap while the overflow count equals overflow compare 1, 5 the same with overflow compare 2. Each event gives one output pulse one cycle long, and no events occur while idle.
- R11: Selector codes 6 and 7 never produce a pulse.
- R12: MUX (address 1) holds the timer select in bits 2:0 and the overflow select in bits 6:4. Select 1 maps the byte registers to the period, 2 to compare 1 and 3 to compare 2; these are written and read back there. Select 0 maps them to the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | 32 kHz reference, asynchronous |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (triggers snapshots) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| evt_o | output | 2 | Selected event pulses |

## Verification
The snapshots are tried on free-running counters. Two multi-byte reads taken hundreds of cycles apart must differ by exactly the elapsed cycle count, which tells a true snapshot from a live or stale upper byte. In latch mode 1 the timer and the overflow count are combined into one value, so a latch taken in two different cycles shows up as an error. Start and stop are tried with the slow input held, falling and rising, which tells an immediate start from a deferred one. Each event code is counted over a window that is a whole number of event periods, so a missing, doubled or misrouted pulse changes the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0, A_MUX = 3'd1, A_TLO = 3'd2, A_THI = 3'd3,
    A_OV0  = 3'd4, A_OV1 = 3'd5, A_OV2 = 3'd6, A_EVT = 3'd7
  } reg_addr_e;

  localparam int SEL_W   = 3;
  localparam int NUM_SRC = 6;
  // event source indices, equal to selector codes
  localparam int SRC_TPER  = 0;
  localparam int SRC_TCMP1 = 1;
  localparam int SRC_TCMP2 = 2;
  localparam int SRC_OPER  = 3;
  localparam int SRC_OCMP1 = 4;
  localparam int SRC_OCMP2 = 5;

  localparam logic [SEL_W-1:0] MS_CNT  = 3'd0;
  localparam logic [SEL_W-1:0] MS_PER  = 3'd1;
  localparam logic [SEL_W-1:0] MS_CMP1 = 3'd2;
  localparam logic [SEL_W-1:0] MS_CMP2 = 3'd3;
endpackage

// File: rtl/tmr_run_sync.sv
module tmr_run_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_clk_i,
  input  logic sync_i,
  input  logic run_req_i,
  output logic state_o
);
  logic [2:0] sl_q;  // [0],[1] synchronizer, [2] edge history
  logic       slow_rise;

  assign slow_rise = sl_q[1] & ~sl_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sl_q    <= '0;
      state_o <= 1'b0;
    end else begin
      sl_q <= {sl_q[1:0], slow_clk_i};
      if (!sync_i || slow_rise) state_o <= run_req_i;
    end
  end

  a_r3_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> state_o == $past(run_req_i));

  a_r4_hold_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !(sl_q[1] && !sl_q[2])) |=> $stable(state_o));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int OVF_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [TMR_W-1:0]   tmr_per_i,
  input  logic [TMR_W-1:0]   tmr_cmp1_i,
  input  logic [TMR_W-1:0]   tmr_cmp2_i,
  input  logic [OVF_W-1:0]   ovf_per_i,
  input  logic [OVF_W-1:0]   ovf_cmp1_i,
  input  logic [OVF_W-1:0]   ovf_cmp2_i,
  output logic [TMR_W-1:0]   tmr_cnt_o,
  output logic [OVF_W-1:0]   ovf_cnt_o,
  output logic [NUM_SRC-1:0] evt_o
);
  logic tmr_wrap, ovf_wrap;

  assign tmr_wrap = run_i && (tmr_cnt_o >= tmr_per_i);
  assign ovf_wrap = tmr_wrap && (ovf_cnt_o >= ovf_per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_cnt_o <= '0;
      ovf_cnt_o <= '0;
    end else if (run_i) begin
      tmr_cnt_o <= tmr_wrap ? '0 : tmr_cnt_o + 1'b1;
      if (tmr_wrap) ovf_cnt_o <= ovf_wrap ? '0 : ovf_cnt_o + 1'b1;
    end
  end

  always_comb begin
    evt_o            = '0;
    evt_o[SRC_TPER]  = tmr_wrap;
    evt_o[SRC_TCMP1] = run_i && (tmr_cnt_o == tmr_cmp1_i);
    evt_o[SRC_TCMP2] = run_i && (tmr_cnt_o == tmr_cmp2_i);
    evt_o[SRC_OPER]  = ovf_wrap;
    evt_o[SRC_OCMP1] = tmr_wrap && (ovf_cnt_o == ovf_cmp1_i);
    evt_o[SRC_OCMP2] = tmr_wrap && (ovf_cnt_o == ovf_cmp2_i);
  end

  a_r5_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tmr_cnt_o < tmr_per_i) |=> tmr_cnt_o == $past(tmr_cnt_o) + 1'b1);

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(tmr_cnt_o) && $stable(ovf_cnt_o)));

  a_r6_ovf_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tmr_cnt_o >= tmr_per_i && ovf_cnt_o < ovf_per_i)
      |=> ovf_cnt_o == $past(ovf_cnt_o) + 1'b1);
endmodule

// File: rtl/tmr_evt_route.sv
module tmr_evt_route
  import tmr_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_SRC-1:0]              src_i,
  input  logic [NUM_OUT-1:0][SEL_W-1:0]   sel_i,
  output logic [NUM_OUT-1:0]              pulse_o
);
  localparam int SEL_N = 1 << SEL_W;

  logic [SEL_N-1:0] src_ext;
  assign src_ext = {{(SEL_N-NUM_SRC){1'b0}}, src_i};  // unused codes read 0

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic pulse_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= src_ext[sel_i[g]];
    end
    assign pulse_o[g] = pulse_q;

    a_r11_reserved_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[g] >= SEL_W'(NUM_SRC)) |=> !pulse_o[g]);

    a_r10_no_idle_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i == '0) |=> !pulse_o[g]);
  end
endmodule

// File: rtl/tmr_latch_ctrl.sv
module tmr_latch_ctrl
  import tmr_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int OVF_W   = 24,
  parameter int NUM_OUT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slow_clk_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [2:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [NUM_OUT-1:0] evt_o
);
  logic                          run_q, sync_q, lmode_q, state;
  logic [SEL_W-1:0]              tsel_q, osel_q;
  logic [TMR_W-1:0]              tper_q, tcmp1_q, tcmp2_q, tcnt, tval;
  logic [OVF_W-1:0]              oper_q, ocmp1_q, ocmp2_q, ocnt, oval;
  logic [NUM_OUT-1:0][SEL_W-1:0] evsel_q;
  logic [7:0]                    thi_lat_q;
  logic [OVF_W-1:0]              olat_q;
  logic [NUM_SRC-1:0]            src;
  logic                          tb;
  logic [1:0]                    ob;
  logic                          rd_tlo, rd_ov0;
  reg_addr_e                     addr;

  assign addr   = reg_addr_e'(addr_i);
  assign tb     = addr_i[0];      // TLO=2 -> 0, THI=3 -> 1
  assign ob     = addr_i[1:0];    // OV0=4 -> 0 .. OV2=6 -> 2
  assign rd_tlo = re_i && addr == A_TLO && tsel_q == MS_CNT;
  assign rd_ov0 = re_i && addr == A_OV0 && osel_q == MS_CNT;

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      sync_q  <= 1'b1;
      lmode_q <= 1'b0;
      tsel_q  <= '0;
      osel_q  <= '0;
      tper_q  <= '1;
      tcmp1_q <= '0;
      tcmp2_q <= '0;
      oper_q  <= '1;
      ocmp1_q <= '0;
      ocmp2_q <= '0;
      evsel_q <= '0;
    end else if (we_i) begin
      case (addr)
        A_CTRL: begin
          run_q   <= wdata_i[0];
          sync_q  <= wdata_i[1];
          lmode_q <= wdata_i[3];
        end
        A_MUX: begin
          tsel_q <= wdata_i[2:0];
          osel_q <= wdata_i[6:4];
        end
        A_TLO, A_THI: begin
          case (tsel_q)
            MS_PER:  tper_q[8*tb +: 8]  <= wdata_i;
            MS_CMP1: tcmp1_q[8*tb +: 8] <= wdata_i;
            MS_CMP2: tcmp2_q[8*tb +: 8] <= wdata_i;
            default: ;
          endcase
        end
        A_OV0, A_OV1, A_OV2: begin
          case (osel_q)
            MS_PER:  oper_q[8*ob +: 8]  <= wdata_i;
            MS_CMP1: ocmp1_q[8*ob +: 8] <= wdata_i;
            MS_CMP2: ocmp2_q[8*ob +: 8] <= wdata_i;
            default: ;
          endcase
        end
        A_EVT: begin
          for (int g = 0; g < NUM_OUT; g++) evsel_q[g] <= wdata_i[4*g +: SEL_W];
        end
        default: ;
      endcase
    end
  end

  // snapshot latches, loaded by low-byte reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thi_lat_q <= '0;
      olat_q    <= '0;
    end else begin
      if (rd_tlo) begin
        thi_lat_q <= tcnt[8 +: 8];
        if (lmode_q) olat_q <= ocnt;
      end
      if (rd_ov0 && !lmode_q) olat_q[OVF_W-1:8] <= ocnt[OVF_W-1:8];
    end
  end

  always_comb begin
    case (tsel_q)
      MS_PER:  tval = tper_q;
      MS_CMP1: tval = tcmp1_q;
      MS_CMP2: tval = tcmp2_q;
      default: tval = '0;
    endcase
    case (osel_q)
      MS_PER:  oval = oper_q;
      MS_CMP1: oval = ocmp1_q;
      MS_CMP2: oval = ocmp2_q;
      default: oval = '0;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      A_CTRL: rdata_o = {4'b0, lmode_q, state, sync_q, run_q};
      A_MUX:  rdata_o = {1'b0, osel_q, 1'b0, tsel_q};
      A_TLO:  rdata_o = (tsel_q == MS_CNT) ? tcnt[7:0] : tval[7:0];
      A_THI:  rdata_o = (tsel_q == MS_CNT) ? thi_lat_q : tval[15:8];
      A_OV0:  rdata_o = (osel_q != MS_CNT) ? oval[7:0] :
                        (lmode_q ? olat_q[7:0] : ocnt[7:0]);
      A_OV1:  rdata_o = (osel_q == MS_CNT) ? olat_q[15:8]  : oval[15:8];
      A_OV2:  rdata_o = (osel_q == MS_CNT) ? olat_q[23:16] : oval[23:16];
      A_EVT:  for (int g = 0; g < NUM_OUT; g++) rdata_o[4*g +: SEL_W] = evsel_q[g];
      default: ;
    endcase
  end

  tmr_run_sync u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slow_clk_i (slow_clk_i),
    .sync_i     (sync_q),
    .run_req_i  (run_q),
    .state_o    (state)
  );

  tmr_count_core #(.TMR_W(TMR_W), .OVF_W(OVF_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (state),
    .tmr_per_i  (tper_q),
    .tmr_cmp1_i (tcmp1_q),
    .tmr_cmp2_i (tcmp2_q),
    .ovf_per_i  (oper_q),
    .ovf_cmp1_i (ocmp1_q),
    .ovf_cmp2_i (ocmp2_q),
    .tmr_cnt_o  (tcnt),
    .ovf_cnt_o  (ocnt),
    .evt_o      (src)
  );

  tmr_evt_route #(.NUM_OUT(NUM_OUT)) u_route (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src),
    .sel_i   (evsel_q),
    .pulse_o (evt_o)
  );

  a_r7_hi_latch_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_tlo |=> $stable(thi_lat_q));

  a_r8_split_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ov0 && !lmode_q) |=> olat_q[OVF_W-1:8] == $past(ocnt[OVF_W-1:8]));

  a_r9_joint_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_tlo && lmode_q) |=> (olat_q == $past(ocnt) && thi_lat_q == $past(tcnt[15:8])));
endmodule

// File: tb/tmr_latch_ctrl_tb.sv
module tmr_latch_ctrl_tb;
  localparam logic [2:0] CTRL = 3'd0, MUX = 3'd1, TLO = 3'd2, THI = 3'd3,
                         OV0 = 3'd4, OV1 = 3'd5, OV2 = 3'd6, EVT = 3'd7;

  logic       clk = 1'b0, rst_n = 1'b0, slow = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] evt;
  int         cyc = 0, n_chk = 0, n_err = 0;
  bit         mon_v = 1'b0, done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_latch_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_o(evt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data, compares just before the edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (mon_v && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); re = 1'b1; addr = a; exp_q.push_back(e); tag_q.push_back(tag); mon_v = 1'b1;
    @(negedge clk); re = 1'b0; mon_v = 1'b0;
  endtask

  task automatic rd_raw(input logic [2:0] a, output logic [7:0] d, output int t);
    @(negedge clk); re = 1'b1; addr = a;
    #3; d = rdata; t = cyc;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_evt(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #3;
      c0 += int'(evt[0]); c1 += int'(evt[1]);
    end
  endtask

  initial begin
    logic [7:0] l1, h1, h1b, l2, h2, a1, b1, c1, a2, b2, c2;
    int t1, t2, tx, m1, m2, e0, e1;

    idle(3);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd_exp(CTRL, 8'h02, "R1 ctrl reset");
    rd_exp(EVT,  8'h00, "R1 evt reset");
    rd_exp(MUX,  8'h00, "R1 mux reset");
    rd_exp(TLO,  8'h00, "R1 count reset");
    wr(MUX, 8'h01);
    rd_exp(THI, 8'hFF, "R1 timer period reset");
    wr(MUX, 8'h10);
    rd_exp(OV2, 8'hFF, "R1 ovf period reset");

    // R12 select and register access
    wr(MUX, 8'h01); wr(TLO, 8'h34);
    rd_exp(TLO, 8'h34, "R12 period low readback");
    wr(TLO, 8'hFF);
    wr(MUX, 8'h22); wr(THI, 8'h5A); wr(OV1, 8'hA5);
    rd_exp(THI, 8'h5A, "R12 cmp1 high readback");
    rd_exp(OV1, 8'hA5, "R12 ovf cmp1 byte1 readback");
    rd_exp(MUX, 8'h22, "R12 mux readback");
    wr(THI, 8'h00); wr(OV1, 8'h00);
    wr(MUX, 8'h00);

    // R2 reserved bits and read-only state
    wr(CTRL, 8'hF6);
    rd_exp(CTRL, 8'h02, "R2 reserved and state bits");

    // R4 deferred start/stop
    wr(CTRL, 8'h03); idle(10);
    rd_exp(CTRL, 8'h03, "R4 no start before slow edge (R2 run readback)");
    @(negedge clk); slow = 1'b1; idle(5);
    rd_exp(CTRL, 8'h07, "R4 start at slow rise");
    wr(CTRL, 8'h02); idle(6);
    rd_exp(CTRL, 8'h06, "R4 still running before slow edge");
    @(negedge clk); slow = 1'b0; idle(5);
    rd_exp(CTRL, 8'h06, "R4 falling edge ignored");
    @(negedge clk); slow = 1'b1; idle(5);
    rd_exp(CTRL, 8'h02, "R4 stop at slow rise");

    // R3 immediate start/stop
    wr(CTRL, 8'h01);
    rd_exp(CTRL, 8'h05, "R3 immediate start");
    wr(CTRL, 8'h00);
    rd_exp(CTRL, 8'h00, "R3 immediate stop");

    // R7 timer high-byte snapshot, mode 0, period all ones
    wr(CTRL, 8'h01); idle(5);
    rd_raw(TLO, l1, t1); idle(300);
    rd_raw(THI, h1, tx); idle(300);
    rd_raw(THI, h1b, tx);
    check("R7 latched high byte held", h1b, h1);
    rd_raw(TLO, l2, t2);
    rd_raw(THI, h2, tx);
    check("R7 R5 snapshot advance", int'(16'({h2, l2} - {h1, l1})), int'(16'(t2 - t1)));

    // R5 idle freezes count
    wr(CTRL, 8'h00);
    rd_raw(TLO, a1, tx); idle(50);
    rd_raw(TLO, a2, tx);
    check("R5 idle holds count", a2, a1);

    // R9 joint snapshot, timer period 3
    wr(MUX, 8'h01); wr(TLO, 8'h03); wr(THI, 8'h00); wr(MUX, 8'h00);
    wr(CTRL, 8'h09); idle(20);
    rd_raw(TLO, l1, t1); idle(300);
    rd_raw(THI, h1, tx);
    rd_raw(OV0, a1, tx); rd_raw(OV1, b1, tx); rd_raw(OV2, c1, tx);
    check("R5 count within period", int'({h1, l1} <= 16'd3), 1);
    m1 = int'({c1, b1, a1}) * 4 + int'({h1, l1});
    idle(300);
    rd_raw(TLO, l2, t2); idle(40);
    rd_raw(THI, h2, tx);
    rd_raw(OV0, a2, tx); rd_raw(OV1, b2, tx); rd_raw(OV2, c2, tx);
    m2 = int'({c2, b2, a2}) * 4 + int'({h2, l2});
    check("R9 R6 joint snapshot advance", m2 - m1, t2 - t1);

    // R8 split overflow snapshot, timer period 0 -> overflow steps every cycle
    wr(MUX, 8'h01); wr(TLO, 8'h00); wr(MUX, 8'h00);
    wr(CTRL, 8'h01); idle(20);
    rd_raw(OV0, a1, t1); idle(300);
    rd_raw(OV1, b1, tx); idle(30);
    rd_raw(OV2, c1, tx);
    idle(300);
    rd_raw(OV0, a2, t2); idle(30);
    rd_raw(OV1, b2, tx); rd_raw(OV2, c2, tx);
    check("R8 R6 overflow snapshot advance",
          int'(24'({c2, b2, a2} - {c1, b1, a1})), int'(24'(t2 - t1)));

    // R10/R11 timer events: period 9, cmp1 4, cmp2 20 (never reached)
    wr(MUX, 8'h01); wr(TLO, 8'h09);
    wr(MUX, 8'h02); wr(TLO, 8'h04);
    wr(MUX, 8'h03); wr(TLO, 8'h14);
    wr(MUX, 8'h00);
    wr(EVT, 8'h10); idle(40);
    count_evt(100, e0, e1);
    check("R10 code0 timer wrap pulses", e0, 10);
    check("R10 code1 timer cmp1 pulses", e1, 10);
    wr(EVT, 8'h62); idle(5);
    count_evt(100, e0, e1);
    check("R10 code2 cmp2 above period", e0, 0);
    check("R11 code6 silent", e1, 0);
    rd_exp(EVT, 8'h62, "R10 selector readback");

    // overflow events: timer period 0, ovf period 4, ovf cmp1 2, ovf cmp2 0
    wr(MUX, 8'h01); wr(TLO, 8'h00);
    wr(MUX, 8'h10); wr(OV0, 8'h04); wr(OV1, 8'h00); wr(OV2, 8'h00);
    wr(MUX, 8'h20); wr(OV0, 8'h02);
    wr(MUX, 8'h00);
    wr(EVT, 8'h43); idle(40);
    count_evt(100, e0, e1);
    check("R10 code3 ovf wrap pulses", e0, 20);
    check("R10 code4 ovf cmp1 pulses", e1, 20);
    wr(EVT, 8'h75); idle(5);
    count_evt(100, e0, e1);
    check("R10 code5 ovf cmp2 pulses", e0, 20);
    check("R11 code7 silent", e1, 0);
    wr(EVT, 8'h30); idle(5);
    count_evt(100, e0, e1);
    check("R10 code0 timer wrap every cycle", e0, 100);
    check("R10 code3 ovf wrap", e1, 20);
    wr(CTRL, 8'h00); idle(5);
    count_evt(50, e0, e1);
    check("R10 no events while idle", e0 + e1, 0);

    idle(3);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule